// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is a general-purpose interval timer for driver software. A write loads a 16-bit start value and a continuous flag. From the next cycle the timer counts down by one on every tick. A tick is a fixed number of system clock cycles, and that number is chosen by the active link mode. The defaults assume a 125 MHz system clock and give tick periods of 81.92 us, 819.2 us and 204.8 us for the three link modes.

When the count steps from 1 to 0, the block raises a one-cycle expiry pulse, which the surrounding status logic records. In one-shot operation the count then rests at zero. In continuous operation the count is refilled with the last written value and keeps running. While the snooze input is high, the timer is frozen. The read view returns the live count together with the continuous flag.

Top module: `gp_timer`

## Requirements
- R1: After synchronous reset, `rd_value` is all zeros (count 0, continuous flag 0) and `expired` is low.
- R2: A cycle with `wr_en` high loads the count and the stored refill value with `wr_data`, latches `wr_cont`, and restarts the tick prescaler from zero. The new count is visible on the cycle after the write. A write takes priority over a tick in the same cycle.
- R3: A running count (non-zero, not snoozed) decreases by exactly one per tick. The tick period is `FAST_DIV` cycles when `link_mode` is 2'b00 (100 Mb/s MII), `SLOW_DIV` cycles for 2'b01 (10 Mb/s MII) and `SER_DIV` cycles for 2'b10 (serial 10 Mb/s). The spare code 2'b11 behaves like 2'b00. The first decrement after a write lands the stated number of cycles after the load becomes visible.
- R4: Expiry is the tick that takes the count from 1 to 0. `expired` is high for exactly that one cycle, in the same cycle in which the count first shows its post-expiry value.
- R5: With the continuous flag clear, the count stays at 0 after expiry and no further pulse appears until the next write.
- R6: With the continuous flag set, expiry loads the count with the last written value instead of 0, and counting continues, so a pulse recurs every value × period cycles.
- R7: While `snooze` is high, neither the count nor the prescaler advances. When `snooze` falls, the prescaler resumes from where it stopped.
- R8: Writing the value 0 leaves the timer idle: the count stays 0 and no expiry pulse is produced, whatever the continuous flag is.
- R9: `rd_value[15:0]` is the live count and `rd_value[16]` is the latched continuous flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Start value for the count |
| wr_cont | input | 1 | Continuous flag written with the value |
| link_mode | input | 2 | Link mode that selects the tick period |
| snooze | input | 1 | Freezes the timer while high |
| rd_value | output | 17 | Read view: continuous flag in bit 16, live count in bits 15:0 |
| expired | output | 1 | One-cycle expiry pulse |

## Verification
The bench counts cycles from the visible load to each decrement in every link mode, including the spare code. A design with an off-by-one prescaler or a wrong mode decode shifts those edges.

It freezes the timer partway through a tick with snooze. A design that cleared the prescaler on snooze, or kept counting through it, would move the next decrement. It also reloads mid-run, which shows whether the prescaler really restarts on a write.

Further cases cover a zero load with the continuous flag set, where a careless design would count 0 down to 0xFFFF or pulse at once, and the one-shot and continuous endings, where the rest value and the refill value differ. Random writes, mode changes and snooze toggles are compared cycle by cycle against a model written from the requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_W = 16;

    typedef enum logic [1:0] {
        LINK_MII_FAST = 2'b00,
        LINK_MII_SLOW = 2'b01,
        LINK_SERIAL   = 2'b10,
        LINK_SPARE    = 2'b11
    } link_mode_e;

    // One software write, as seen by the counter.
    typedef struct packed {
        logic             strobe;
        logic             cont;
        logic [TMR_W-1:0] value;
    } tmr_load_t;

    // Cycles per tick for a link mode; the spare code uses the fast period.
    function automatic int tick_cycles(link_mode_e mode, int fast_div,
                                       int slow_div, int ser_div);
        case (mode)
            LINK_MII_SLOW: return slow_div;
            LINK_SERIAL:   return ser_div;
            default:       return fast_div;
        endcase
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int FAST_DIV = 10240,
    parameter int SLOW_DIV = 102400,
    parameter int SER_DIV  = 25600
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       enable,
    input  link_mode_e mode,
    output logic       tick
);
    localparam int MAX_DIV = max3(FAST_DIV, SLOW_DIV, SER_DIV);
    localparam int DIV_W   = $clog2(MAX_DIV + 1);

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] last_phase;
    logic             at_end;

    always_comb begin
        last_phase = DIV_W'(tick_cycles(mode, FAST_DIV, SLOW_DIV, SER_DIV) - 1);
        // >= keeps a mode switch to a shorter period from wrapping the phase.
        at_end     = (phase_q >= last_phase);
        tick       = enable && !restart && at_end;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (enable) begin
            if (at_end) phase_q <= '0;
            else        phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = TMR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_load_t        load,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             cont,
    output logic             active,
    output logic             expired
);
    logic [CNT_W-1:0] refill_q;
    logic             last_step;

    assign active    = (count != '0);
    assign last_step = (count == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            refill_q <= '0;
            cont     <= 1'b0;
            expired  <= 1'b0;
        end else if (load.strobe) begin
            count    <= CNT_W'(load.value);
            refill_q <= CNT_W'(load.value);
            cont     <= load.cont;
            expired  <= 1'b0;
        end else if (tick && active) begin
            if (last_step) begin
                count   <= cont ? refill_q : '0;
                expired <= 1'b1;
            end else begin
                count   <= count - 1'b1;
                expired <= 1'b0;
            end
        end else begin
            expired <= 1'b0;
        end
    end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W    = TMR_W,
    parameter int FAST_DIV = 10240,
    parameter int SLOW_DIV = 102400,
    parameter int SER_DIV  = 25600
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             wr_cont,
    input  logic [1:0]       link_mode,
    input  logic             snooze,
    output logic [CNT_W:0]   rd_value,
    output logic             expired
);
    tmr_load_t        load;
    logic             tick;
    logic             active;
    logic             cont;
    logic [CNT_W-1:0] count;

    always_comb begin
        load.strobe = wr_en;
        load.cont   = wr_cont;
        load.value  = TMR_W'(wr_data);
    end

    tmr_prescaler #(
        .FAST_DIV(FAST_DIV),
        .SLOW_DIV(SLOW_DIV),
        .SER_DIV (SER_DIV)
    ) u_pre (
        .clk    (clk),
        .rst    (rst),
        .restart(wr_en),
        .enable (active && !snooze),
        .mode   (link_mode_e'(link_mode)),
        .tick   (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .tick   (tick),
        .count  (count),
        .cont   (cont),
        .active (active),
        .expired(expired)
    );

    assign rd_value = {cont, count};
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic             wr_cont,
    input logic             snooze,
    input logic [CNT_W:0]   rd_value,
    input logic             expired
);
    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_value[CNT_W-1:0] == $past(wr_data) && rd_value[CNT_W] == $past(wr_cont)));

    // R3
    step_size_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && rd_value[CNT_W-1:0] != CNT_W'(1)) |=>
        (rd_value[CNT_W-1:0] == $past(rd_value[CNT_W-1:0]) ||
         rd_value[CNT_W-1:0] == $past(rd_value[CNT_W-1:0]) - CNT_W'(1)));

    // R4
    expiry_from_one_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(expired) |-> $past(rd_value[CNT_W-1:0]) == CNT_W'(1));

    // R5
    oneshot_rest_chk: assert property (@(posedge clk) disable iff (rst)
        (expired && !rd_value[CNT_W]) |-> rd_value[CNT_W-1:0] == '0);

    // R5
    oneshot_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (expired && !rd_value[CNT_W]) |=> !expired);

    // R6
    refill_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (expired && rd_value[CNT_W]) |-> rd_value[CNT_W-1:0] != '0);

    // R7
    snooze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (snooze && !wr_en) |=> $stable(rd_value));

    // R8
    zero_load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data == '0) |=> (rd_value[CNT_W-1:0] == '0 && !expired));
endmodule

bind gp_timer gp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_cont (wr_cont),
    .snooze  (snooze),
    .rd_value(rd_value),
    .expired (expired)
);

// File: tb/gp_timer_tb.sv
module gp_timer_tb;
    localparam int W  = 16;
    localparam int PF = 4;
    localparam int PS = 9;
    localparam int PR = 6;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [W-1:0] wr_data;
    logic         wr_cont;
    logic [1:0]   link_mode;
    logic         snooze;
    logic [W:0]   rd_value;
    logic         expired;

    int n_chk  = 0;
    int n_fail = 0;
    bit model_on = 1'b0;

    always #4 clk = ~clk;

    gp_timer #(.CNT_W(W), .FAST_DIV(PF), .SLOW_DIV(PS), .SER_DIV(PR)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_cont(wr_cont),
        .link_mode(link_mode), .snooze(snooze), .rd_value(rd_value), .expired(expired)
    );

    function automatic int period(logic [1:0] m);
        case (m)
            2'b01:   return PS;
            2'b10:   return PR;
            default: return PF;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(logic [W-1:0] v, logic c);
        wr_en = 1'b1; wr_data = v; wr_cont = c;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Requirement-level model, advanced once per clock edge.
    logic [W-1:0] m_cnt, m_ref;
    logic         m_cont, m_exp;
    int           m_ph;
    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0; m_ref <= '0; m_cont <= 1'b0; m_exp <= 1'b0; m_ph <= 0;
        end else if (wr_en) begin
            m_cnt <= wr_data; m_ref <= wr_data; m_cont <= wr_cont; m_exp <= 1'b0; m_ph <= 0;
        end else if (m_cnt != 0 && !snooze) begin
            if (m_ph >= period(link_mode) - 1) begin
                m_ph <= 0;
                if (m_cnt == 1) begin
                    m_cnt <= m_cont ? m_ref : '0;
                    m_exp <= 1'b1;
                end else begin
                    m_cnt <= m_cnt - 1'b1;
                    m_exp <= 1'b0;
                end
            end else begin
                m_ph  <= m_ph + 1;
                m_exp <= 1'b0;
            end
        end else begin
            m_exp <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            check("R3/R6/R7 random count", 32'(rd_value), 32'({m_cont, m_cnt}));
            check("R4 random pulse", 32'(expired), 32'(m_exp));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int pulses;
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; wr_cont = 1'b0;
        link_mode = 2'b00; snooze = 1'b0;
        cyc(3);
        check("R1 reset count", 32'(rd_value), 32'h0);
        check("R1 reset pulse", 32'(expired), 32'h0);
        rst = 1'b0;
        cyc(2);

        // One-shot in fast mode: value 3, period PF.
        write(16'd3, 1'b0);
        check("R2 loaded", 32'(rd_value), 32'd3);
        check("R9 cont bit clear", 32'(rd_value[W]), 32'd0);
        cyc(PF - 1);
        check("R3 before first tick", 32'(rd_value), 32'd3);
        cyc(1);
        check("R3 first tick fast", 32'(rd_value), 32'd2);
        cyc(2 * PF - 1);
        check("R4 no early pulse", 32'(expired), 32'd0);
        cyc(1);
        check("R4 expiry count", 32'(rd_value), 32'd0);
        check("R4 expiry pulse", 32'(expired), 32'd1);
        cyc(1);
        check("R4 pulse one cycle", 32'(expired), 32'd0);
        pulses = 0;
        for (int i = 0; i < 25; i++) begin cyc(1); if (expired) pulses++; end
        check("R5 no repeat pulse", 32'(pulses), 32'd0);
        check("R5 rests at zero", 32'(rd_value), 32'd0);

        // Slow MII and serial periods.
        link_mode = 2'b01;
        write(16'd2, 1'b0);
        cyc(PS - 1);
        check("R3 slow before tick", 32'(rd_value), 32'd2);
        cyc(1);
        check("R3 slow tick", 32'(rd_value), 32'd1);
        link_mode = 2'b10;
        write(16'd2, 1'b0);
        cyc(PR - 1);
        check("R3 serial before tick", 32'(rd_value), 32'd2);
        cyc(1);
        check("R3 serial tick", 32'(rd_value), 32'd1);
        link_mode = 2'b11;
        write(16'd1, 1'b0);
        cyc(PF);
        check("R3 spare code uses fast period", 32'(expired), 32'd1);

        // Continuous mode.
        link_mode = 2'b00;
        write(16'd2, 1'b1);
        check("R9 cont bit set", 32'(rd_value[W]), 32'd1);
        cyc(2 * PF);
        check("R6 first pulse", 32'(expired), 32'd1);
        check("R6 refilled", 32'(rd_value[W-1:0]), 32'd2);
        cyc(2 * PF);
        check("R6 second pulse", 32'(expired), 32'd1);

        // Snooze in the middle of a tick.
        write(16'd5, 1'b0);
        cyc(2);
        snooze = 1'b1;
        cyc(10);
        check("R7 frozen", 32'(rd_value), 32'd5);
        snooze = 1'b0;
        cyc(1);
        check("R7 phase kept", 32'(rd_value), 32'd5);
        cyc(1);
        check("R7 resumed", 32'(rd_value), 32'd4);

        // Zero load with continuous flag.
        write(16'd0, 1'b1);
        pulses = 0;
        for (int i = 0; i < 30; i++) begin cyc(1); if (expired) pulses++; end
        check("R8 zero stays idle", 32'(rd_value[W-1:0]), 32'd0);
        check("R8 no pulse", 32'(pulses), 32'd0);
        check("R9 flag with zero", 32'(rd_value[W]), 32'd1);

        // Reload mid-tick restarts the prescaler.
        write(16'd9, 1'b0);
        cyc(PF - 1);
        write(16'd7, 1'b0);
        cyc(PF - 1);
        check("R2 prescaler restarted", 32'(rd_value), 32'd7);
        cyc(1);
        check("R2 tick after reload", 32'(rd_value), 32'd6);

        // Random phase against the model.
        model_on = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            wr_en = 1'b0;
            if ($urandom_range(39) == 0) begin
                wr_en = 1'b1;
                wr_data = 16'($urandom_range(6));
                wr_cont = 1'($urandom_range(1));
            end
            if ($urandom_range(199) == 0) link_mode = 2'($urandom_range(3));
            if ($urandom_range(29) == 0) snooze = ~snooze;
            @(negedge clk);
        end
        model_on = 1'b0;
        wr_en = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule